// File: doc/BRIEF.md
# Dual-Speed Bit-Swapping Address Generator

This block produces the address sequence for a memory self-test pass that only needs to touch every location once, in any order, using as few address-line transitions as it can. The address is split into two fields, each driven by its own linear feedback shift register. The low field advances on every accepted address. The high field advances only when the low register has run through its whole period and come back to its seed, so the upper address lines change about once every 2^FAST_W - 1 addresses.

Neither register drives the address directly. Each one passes through a swap network that exchanges neighbouring bit pairs whenever the register's top bit is 0. The swap is a bijection for each value of the selector, so coverage is unchanged: the block delivers every pairing of non-zero low and high values exactly once, then raises a done flag. The address leaves the block as a valid/ready stream. The consumer stalls the sequence by holding ready low. A seed load restarts the sequence from new seeds at any time.

Top module: `dsbs_addr_gen`

## Requirements
- R1: After reset, addr_valid_o is 1 and done_o is 0. addr_o is the transform (R4, R5) of the parameter seeds FAST_SEED and SLOW_SEED. With the default seeds of 1 and widths 4 and 3, addr_o is 7'h22.
- R2: A handshake (addr_valid_o and addr_ready_i both 1 at a rising edge, with seed_load_i 0) advances the fast register by one step. One step is a left shift with new bit 0 equal to the XOR of the state bits selected by the tap mask. The mask for width 4 is 4'b1100 and for width 3 is 3'b110.
- R3: The slow register advances, by the same kind of step, only on a handshake whose fast step lands back on the fast seed. At all other times it holds its value.
- R4: Each field of the address is its register's state with bit W-1 passed through as the selector. When the selector is 0, the bits 2k and 2k+1 are exchanged for every pair below W-1. A leftover bit W-2, if there is one, always passes through unchanged.
- R5: addr_o is {slow field, fast field}, with the fast field in the low FAST_W bits.
- R6: While addr_valid_o is 1 and addr_ready_i is 0, addr_o holds its value into the next cycle (back-pressure).
- R7: From a seed load or reset to done, exactly (2^FAST_W-1)*(2^SLOW_W-1) handshakes occur. All of their addresses are distinct, and neither field is ever all zeros.
- R8: done_o rises in the cycle after the last handshake of a pass, and addr_valid_o is 0 while done_o is 1. While done, addr_ready_i has no effect on addr_o or on done_o.
- R9: seed_load_i has priority over a handshake. While it is 1, addr_valid_o is 0. In the next cycle done_o is 0 and addr_o is the transform of the loaded seeds.
- R10: A loaded seed of all zeros is replaced by the value 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seed_load_i | input | 1 | Restart the pass from the seed inputs |
| fast_seed_i | input | FAST_W | Seed for the low-field register |
| slow_seed_i | input | SLOW_W | Seed for the high-field register |
| addr_ready_i | input | 1 | Consumer accepts the current address |
| addr_valid_o | output | 1 | An address is on offer |
| addr_o | output | FAST_W+SLOW_W | Current address |
| done_o | output | 1 | Every address of the pass has been accepted |

## Verification
The bench builds the block with a 4-bit fast field and a 3-bit slow field. A full pass is then 105 addresses, short enough to walk several complete passes. Each pass contains seven slow-field advances, and one of them carries the slow register back through its own wrap, so the done condition is reached. These widths also give the swap network both of its shapes: an odd number of bits below the selector (fast) and an even number (slow).

// File: rtl/dsbs_pkg.sv
package dsbs_pkg;

  localparam int unsigned MAX_W = 16;

  // Maximal-length feedback masks for a left-shifting register:
  // bit t-1 set means state bit t-1 feeds the XOR.
  function automatic logic [MAX_W-1:0] tap_mask(input int unsigned w);
    logic [MAX_W-1:0] m;
    m = '0;
    case (w)
      2:  m = 16'h0003;
      3:  m = 16'h0006;
      4:  m = 16'h000C;
      5:  m = 16'h0014;
      6:  m = 16'h0030;
      7:  m = 16'h0060;
      8:  m = 16'h00B8;
      9:  m = 16'h0110;
      10: m = 16'h0240;
      11: m = 16'h0500;
      12: m = 16'h0829;
      13: m = 16'h100D;
      14: m = 16'h2015;
      15: m = 16'h6000;
      16: m = 16'hD008;
      default: m = 16'h0003;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dsbs_swap_net.sv
module dsbs_swap_net #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] state_i,
  output logic [W-1:0] word_o
);
  localparam int unsigned NPAIR = (W - 1) / 2;
  localparam bit          ODD   = ((W - 1) % 2) == 1;

  logic sel_keep;
  assign sel_keep   = state_i[W-1];
  assign word_o[W-1] = state_i[W-1];

  genvar k;
  generate
    for (k = 0; k < NPAIR; k++) begin : g_pair
      assign word_o[2*k]   = sel_keep ? state_i[2*k]   : state_i[2*k+1];
      assign word_o[2*k+1] = sel_keep ? state_i[2*k+1] : state_i[2*k];
    end
    if (ODD) begin : g_tail
      assign word_o[W-2] = state_i[W-2];
    end
  endgenerate
endmodule

// File: rtl/dsbs_lfsr_core.sv
module dsbs_lfsr_core
  import dsbs_pkg::*;
#(
  parameter int unsigned W        = 4,
  parameter logic [W-1:0] RST_SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o,
  output logic         wrap_o
);
  localparam logic [MAX_W-1:0] TAP_ALL = tap_mask(W);
  localparam logic [W-1:0]     TAP     = TAP_ALL[W-1:0];
  localparam logic [W-1:0]     SAFE_RST = (RST_SEED == '0) ? W'(1) : RST_SEED;

  logic [W-1:0] state_q, seed_q, next_state, seed_fix;
  logic         fb;

  assign seed_fix   = (seed_i == '0) ? W'(1) : seed_i;
  assign fb         = ^(state_q & TAP);

  generate
    if (W > 1) begin : g_shift
      assign next_state = {state_q[W-2:0], fb};
    end else begin : g_one
      assign next_state = state_q;
    end
  endgenerate

  assign wrap_o = (next_state == seed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SAFE_RST;
      seed_q  <= SAFE_RST;
    end else if (load_i) begin
      state_q <= seed_fix;
      seed_q  <= seed_fix;
    end else if (adv_i) begin
      state_q <= next_state;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dsbs_step_ctrl.sv
module dsbs_step_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic ready_i,
  input  logic fast_wrap_i,
  input  logic slow_wrap_i,
  output logic valid_o,
  output logic done_o,
  output logic fast_adv_o,
  output logic slow_adv_o
);
  logic done_q, fire, last_step;

  assign valid_o    = !done_q && !load_i;
  assign fire       = valid_o && ready_i;
  assign fast_adv_o = fire;
  assign slow_adv_o = fire && fast_wrap_i;
  assign last_step  = slow_adv_o && slow_wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        done_q <= 1'b0;
    else if (load_i)    done_q <= 1'b0;
    else if (last_step) done_q <= 1'b1;
  end

  assign done_o = done_q;
endmodule

// File: rtl/dsbs_addr_gen.sv
module dsbs_addr_gen #(
  parameter int unsigned        FAST_W    = 4,
  parameter int unsigned        SLOW_W    = 3,
  parameter logic [FAST_W-1:0]  FAST_SEED = 1,
  parameter logic [SLOW_W-1:0]  SLOW_SEED = 1,
  localparam int unsigned       ADDR_W    = FAST_W + SLOW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_load_i,
  input  logic [FAST_W-1:0] fast_seed_i,
  input  logic [SLOW_W-1:0] slow_seed_i,
  input  logic              addr_ready_i,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic              fast_adv, slow_adv, fast_wrap, slow_wrap;
  logic [FAST_W-1:0] fast_state, fast_word;
  logic [SLOW_W-1:0] slow_state, slow_word;

  dsbs_step_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (seed_load_i),
    .ready_i     (addr_ready_i),
    .fast_wrap_i (fast_wrap),
    .slow_wrap_i (slow_wrap),
    .valid_o     (addr_valid_o),
    .done_o      (done_o),
    .fast_adv_o  (fast_adv),
    .slow_adv_o  (slow_adv)
  );

  dsbs_lfsr_core #(.W(FAST_W), .RST_SEED(FAST_SEED)) u_fast (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load_i),
    .seed_i  (fast_seed_i),
    .adv_i   (fast_adv),
    .state_o (fast_state),
    .wrap_o  (fast_wrap)
  );

  dsbs_lfsr_core #(.W(SLOW_W), .RST_SEED(SLOW_SEED)) u_slow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load_i),
    .seed_i  (slow_seed_i),
    .adv_i   (slow_adv),
    .state_o (slow_state),
    .wrap_o  (slow_wrap)
  );

  dsbs_swap_net #(.W(FAST_W)) u_fast_swap (.state_i(fast_state), .word_o(fast_word));
  dsbs_swap_net #(.W(SLOW_W)) u_slow_swap (.state_i(slow_state), .word_o(slow_word));

  assign addr_o = {slow_word, fast_word};
endmodule

// File: rtl/dsbs_addr_gen_chk.sv
module dsbs_addr_gen_chk #(
  parameter int unsigned FAST_W = 4,
  parameter int unsigned SLOW_W = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     seed_load_i,
  input logic                     addr_ready_i,
  input logic                     addr_valid_o,
  input logic [FAST_W+SLOW_W-1:0] addr_o,
  input logic                     done_o
);
  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i && !seed_load_i) |=> $stable(addr_o));

  // R8
  done_blocks_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !addr_valid_o);

  // R8
  done_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !seed_load_i) |=> (done_o && $stable(addr_o)));

  // R8
  done_after_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(addr_valid_o && addr_ready_i));

  // R7
  fast_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> (addr_o[FAST_W-1:0] != '0));

  // R7
  slow_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> (addr_o[FAST_W+SLOW_W-1:FAST_W] != '0));

  // R9
  load_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> !done_o);

  // R9
  load_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |-> !addr_valid_o);
endmodule

bind dsbs_addr_gen dsbs_addr_gen_chk #(.FAST_W(FAST_W), .SLOW_W(SLOW_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .seed_load_i  (seed_load_i),
  .addr_ready_i (addr_ready_i),
  .addr_valid_o (addr_valid_o),
  .addr_o       (addr_o),
  .done_o       (done_o)
);

// File: tb/dsbs_addr_gen_tb_top.sv
module dsbs_addr_gen_tb_top;
  localparam int FW = 4;
  localparam int SW = 3;
  localparam int AW = FW + SW;
  localparam int PASS_LEN = ((1 << FW) - 1) * ((1 << SW) - 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          seed_load_i = 1'b0;
  logic [FW-1:0] fast_seed_i = '0;
  logic [SW-1:0] slow_seed_i = '0;
  logic          addr_ready_i = 1'b0;
  logic          addr_valid_o;
  logic [AW-1:0] addr_o;
  logic          done_o;

  int checks = 0;
  int fails  = 0;
  int hs_cnt = 0;
  int distinct = 0;
  bit seen [int];
  logic [AW-1:0] exp_q [$];
  bit            stall_pend = 0;
  logic [AW-1:0] stall_addr;
  int            cyc = 0;

  always #4 clk_i = ~clk_i;

  dsbs_addr_gen #(.FAST_W(FW), .SLOW_W(SW), .FAST_SEED(4'd1), .SLOW_SEED(3'd1)) dut_i (
    .clk_i, .rst_ni, .seed_load_i, .fast_seed_i, .slow_seed_i,
    .addr_ready_i, .addr_valid_o, .addr_o, .done_o
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 step with the requirement's tap masks
  function automatic logic [7:0] step(input logic [7:0] s, input int w);
    logic [7:0] m, r;
    m = (w == 4) ? 8'h0C : 8'h06;
    r = (s << 1) | {7'd0, ^(s & m)};
    return r & ((8'd1 << w) - 8'd1);
  endfunction

  // R4 swap transform
  function automatic logic [7:0] swp(input logic [7:0] s, input int w);
    logic [7:0] r;
    r = s;
    if (!s[w-1])
      for (int k = 0; 2*k+1 < w-1; k++) begin
        r[2*k]   = s[2*k+1];
        r[2*k+1] = s[2*k];
      end
    return r;
  endfunction

  // driver: fill the scoreboard with one whole pass (R3, R5)
  task automatic fill(input logic [3:0] f0, input logic [2:0] s0);
    logic [7:0] f, s, fn, ff, sf;
    ff = (f0 == 0) ? 8'd1 : {4'd0, f0};
    sf = (s0 == 0) ? 8'd1 : {5'd0, s0};
    exp_q.delete();
    seen.delete();
    distinct = 0;
    hs_cnt = 0;
    f = ff; s = sf;
    for (int n = 0; n < PASS_LEN; n++) begin
      logic [7:0] a;
      a = {swp(s, SW), 4'b0} | {4'b0, swp(f, FW)[3:0]};
      exp_q.push_back(a[AW-1:0]);
      fn = step(f, FW);
      if (fn == ff) s = step(s, SW);
      f = fn;
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (stall_pend) check(addr_o == stall_addr, "R6 stall hold", addr_o, stall_addr);
      stall_pend = addr_valid_o && !addr_ready_i && !seed_load_i;
      stall_addr = addr_o;
      if (addr_valid_o && addr_ready_i && !seed_load_i) begin
        if (exp_q.size() == 0) check(0, "R7 extra address", addr_o, 0);
        else begin
          logic [AW-1:0] e;
          e = exp_q.pop_front();
          check(addr_o == e, "R2/R3/R4/R5 address", addr_o, e);
        end
        if (!seen.exists(int'(addr_o))) begin seen[int'(addr_o)] = 1; distinct++; end
        hs_cnt++;
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic do_load(input logic [3:0] f, input logic [2:0] s, input bit rdy);
    @(posedge clk_i); #1;
    seed_load_i = 1; fast_seed_i = f; slow_seed_i = s; addr_ready_i = rdy;
    #2 check(addr_valid_o == 0, "R9 valid low in load", addr_valid_o, 0);
    @(posedge clk_i); #1;
    seed_load_i = 0; addr_ready_i = 0;
    fill(f, s);
  endtask

  task automatic run(input int target, input int mode);
    while (hs_cnt < target) begin
      @(posedge clk_i); #1;
      addr_ready_i = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end
    addr_ready_i = 0;
  endtask

  initial begin
    fill(4'd1, 3'd1);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    // R1
    check(addr_valid_o == 1, "R1 valid", addr_valid_o, 1);
    check(done_o == 0, "R1 done", done_o, 0);
    check(addr_o == 7'h22, "R1 addr", addr_o, 7'h22);

    // full pass, ready always high
    run(PASS_LEN, 0);
    @(negedge clk_i);
    check(done_o == 1, "R8 done rises", done_o, 1);
    check(addr_valid_o == 0, "R8 valid low", addr_valid_o, 0);
    check(distinct == PASS_LEN, "R7 distinct", distinct, PASS_LEN);
    check(exp_q.size() == 0, "R7 count", exp_q.size(), 0);

    // R8 ready ignored while done
    begin
      logic [AW-1:0] held;
      held = addr_o;
      @(posedge clk_i); #1 addr_ready_i = 1;
      repeat (5) @(posedge clk_i);
      @(negedge clk_i);
      check(addr_o == held, "R8 addr held while done", addr_o, held);
      check(done_o == 1, "R8 done stays", done_o, 1);
      check(hs_cnt == PASS_LEN, "R8 no handshake", hs_cnt, PASS_LEN);
      addr_ready_i = 0;
    end

    // R9 new seeds, stalling consumer (R6)
    do_load(4'b1010, 3'b101, 1'b1);
    @(negedge clk_i);
    check(done_o == 0, "R9 done cleared", done_o, 0);
    check(addr_o == exp_q[0], "R9 first addr", addr_o, exp_q[0]);
    run(PASS_LEN, 1);
    @(negedge clk_i);
    check(done_o == 1, "R8 done second pass", done_o, 1);
    check(distinct == PASS_LEN, "R7 distinct second pass", distinct, PASS_LEN);

    // R10 zero seeds behave as seed 1
    do_load(4'd0, 3'd0, 1'b0);
    @(negedge clk_i);
    check(addr_o == 7'h22, "R10 zero seed", addr_o, 7'h22);
    run(20, 1);
    // R9 reload mid-pass with ready high
    do_load(4'b0111, 3'b011, 1'b1);
    @(negedge clk_i);
    check(hs_cnt == 0, "R9 load discards handshake", hs_cnt, 0);
    check(addr_o == exp_q[0], "R9 reload addr", addr_o, exp_q[0]);
    run(PASS_LEN, 0);
    @(negedge clk_i);
    check(done_o == 1, "R8 done third pass", done_o, 1);
    check(distinct == PASS_LEN, "R7 distinct third pass", distinct, PASS_LEN);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule